// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block sits on the host side of a 16-bit sampling converter that returns its result over a serial line. When the host pulses `start`, the controller drives the read/convert line low to begin a conversion. It watches the converter's busy flag. It then generates a burst of data-clock pulses and shifts the serial bits into a parallel word. The word is presented on `result` together with a one-cycle `resultValid` strobe.

Two read timings are offered, chosen by `modeAfter` when the start is accepted:

- **Early mode** (`modeAfter` = 0) reads the word left by the previous conversion. It does this while the new conversion is still running, and there is no sync bit. The burst must finish within the first half of the busy period. For that reason only fast data-clock settings are accepted in this mode.
- **Late mode** (`modeAfter` = 1) waits for the conversion to end. It sends one preamble pulse with chip select high to arm the sync output. It then clocks a sync bit followed by the new word. The word is only accepted when the sync bit reads high.

The data-clock half period is taken from `divHalf`, counted in system clocks. A setting that would push the data clock above its rated maximum is refused.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset `rdConv` is 1, `csN` is 1, `dataClk` is 0, `result` is 0, and `resultValid`, `syncErr` and `cfgErr` are all 0.
- R2: A start with an accepted setting drives `rdConv` low (convert). `rdConv` stays low until the cycle after `busyN` is seen low, then returns to 1. Exactly one conversion is started per accepted start.
- R3: In early mode, as soon as busy is seen low, exactly 17 `dataClk` pulses are issued with `csN` low. The word is taken MSB first from `sdata` on rising edges 2 through 17. The last falling edge lies within the first half of the busy-low time (CONV_CYC/2 cycles).
- R4: In late mode, no `dataClk` edge occurs while `busyN` is low. After busy returns high, one pulse is issued with `csN` high, then 18 pulses with `csN` low. The sync bit is sampled on rising edge 2 of those 18, and the word MSB first on rising edges 3 through 18.
- R5: In late mode, a sync bit sampled as 0 raises `syncErr` for one cycle. In that case `resultValid` stays 0 and `result` keeps its previous value.
- R6: `result` changes only in the cycle in which `resultValid` is 1, and `resultValid` is high for exactly one cycle per completed read.
- R7: `dataClk` stays high for `divHalf` system clocks and low for `divHalf` system clocks. A start with `divHalf` below MIN_HALF (4 with the default 100 MHz clock and 15.15 MHz limit) produces a one-cycle `cfgErr`, starts no conversion and issues no `dataClk` pulse.
- R8: In early mode, a start with `divHalf` above EARLY_MAX_HALF (5 by default) is refused in the same way as in R7. The same setting is accepted in late mode.
- R9: A `start` pulse that arrives while a conversion or read is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion and read |
| modeAfter | input | 1 | 0: early read during conversion, 1: late read after conversion with sync |
| divHalf | input | DIV_W | Data-clock half period in system clocks, latched at start |
| busyN | input | 1 | Converter busy flag, low while converting |
| sdata | input | 1 | Serial data from the converter |
| rdConv | output | 1 | Read/convert control, low requests a conversion |
| csN | output | 1 | Chip select, low during the data burst |
| dataClk | output | 1 | Discontinuous data clock |
| result | output | WORD_W | Last accepted word |
| resultValid | output | 1 | One-cycle strobe for a new word |
| syncErr | output | 1 | One-cycle strobe: late-mode sync bit read low |
| cfgErr | output | 1 | One-cycle strobe: start refused for its divider setting |

## Verification
The assertions assume that `busyN` and `sdata` are synchronous to `clk`. They also assume that busy falls only in response to a convert request, and that it stays low for a whole conversion. The converter model in the bench follows these rules. It lowers busy one cycle after it sees `rdConv` fall and holds it low for a fixed conversion length. It changes `sdata` only in the cycle after it sees a data-clock falling edge. As a result, every sampled bit has settled for several system clocks before the controller's next rising edge. The model drives a sync bit only when it has seen a preamble pulse with chip select high, so a missing preamble shows up as a sync error.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_READ,
    ST_WAIT,
    ST_PRE,
    ST_DONE
  } rdState_t;

  // which burst the clock generator should play
  typedef enum logic [1:0] {
    BURST_PRE,
    BURST_EARLY,
    BURST_LATE
  } burst_t;

  typedef struct packed {
    logic   load;       // start a burst this cycle
    burst_t burst;      // burst kind for load
    logic   latchCfg;   // capture the divider setting
    logic   commit;     // finish the read, publish or flag
    logic   checkSync;  // commit must test the sync bit
  } rdStrobe_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int MIN_HALF       = 4,
  parameter int EARLY_MAX_HALF = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeAfter,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             busyN,
  input  logic             genIdle,
  output rdStrobe_t        strb,
  output logic             rdConv,
  output logic             csN,
  output logic             cfgErr
);

  rdState_t state, nextState;
  logic     lateQ;
  logic     cfgErrQ;
  logic     cfgOk;
  logic     fastEnough;
  logic     earlyFits;

  // data clock rate limit, and the early-read window limit
  assign fastEnough = divHalf >= DIV_W'(MIN_HALF);
  assign earlyFits  = divHalf <= DIV_W'(EARLY_MAX_HALF);
  assign cfgOk      = fastEnough && (modeAfter || earlyFits);

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start && cfgOk) begin
          strb.latchCfg = 1'b1;
          nextState     = ST_CONV;
        end
      end
      ST_CONV: begin
        if (!busyN) begin
          if (lateQ) begin
            nextState = ST_WAIT;
          end else begin
            strb.load  = 1'b1;
            strb.burst = BURST_EARLY;
            nextState  = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (genIdle) begin
          nextState = lateQ ? ST_DONE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (busyN) begin
          if (lateQ) begin
            strb.load  = 1'b1;
            strb.burst = BURST_PRE;
            nextState  = ST_PRE;
          end else begin
            nextState = ST_DONE;
          end
        end
      end
      ST_PRE: begin
        if (genIdle) begin
          strb.load  = 1'b1;
          strb.burst = BURST_LATE;
          nextState  = ST_READ;
        end
      end
      ST_DONE: begin
        strb.commit    = 1'b1;
        strb.checkSync = lateQ;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lateQ   <= 1'b0;
      cfgErrQ <= 1'b0;
    end else begin
      state   <= nextState;
      cfgErrQ <= (state == ST_IDLE) && start && !cfgOk;
      if (strb.latchCfg) lateQ <= modeAfter;
    end
  end

  assign rdConv = (state != ST_CONV);
  assign csN    = (state != ST_READ);
  assign cfgErr = cfgErrQ;

endmodule

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              sdata,
  output logic              dataClk,
  output logic              genIdle,
  output logic [WORD_W-1:0] result,
  output logic              resultValid,
  output logic              syncErr
);

  localparam int CNT_W = $clog2(WORD_W + 3);
  localparam logic [CNT_W-1:0] N_PRE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] N_EARLY     = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] N_LATE      = CNT_W'(WORD_W + 2);
  localparam logic [CNT_W-1:0] FIRST_EARLY = CNT_W'(2);
  localparam logic [CNT_W-1:0] FIRST_LATE  = CNT_W'(3);
  localparam logic [CNT_W-1:0] SYNC_RISE   = CNT_W'(2);

  logic [DIV_W-1:0]  divQ;
  logic [DIV_W-1:0]  halfCnt;
  logic              dclkQ;
  logic [CNT_W-1:0]  pulsesLeft;
  logic [CNT_W-1:0]  riseIdx;
  logic [CNT_W-1:0]  firstIdx;
  logic              sampleQ;
  logic              syncEnQ;
  logic              syncQ;
  logic [WORD_W-1:0] shiftQ;
  logic [WORD_W-1:0] resultQ;
  logic              validQ;
  logic              errQ;

  logic             active;
  logic             edgeNow;
  logic             riseNow;
  logic [CNT_W-1:0] riseNum;
  logic             takeBit;
  logic             takeSync;

  assign active   = (pulsesLeft != '0);
  assign edgeNow  = active && (halfCnt == divQ - DIV_W'(1));
  assign riseNow  = edgeNow && !dclkQ;
  assign riseNum  = riseIdx + CNT_W'(1);
  assign takeBit  = riseNow && sampleQ && (riseNum >= firstIdx);
  assign takeSync = riseNow && syncEnQ && (riseNum == SYNC_RISE);

  // divider setting
  always_ff @(posedge clk) begin
    if (!rstN) divQ <= DIV_W'(1);
    else if (strb.latchCfg) divQ <= divHalf;
  end

  // burst clock generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt    <= '0;
      dclkQ      <= 1'b0;
      pulsesLeft <= '0;
      riseIdx    <= '0;
      firstIdx   <= FIRST_EARLY;
      sampleQ    <= 1'b0;
      syncEnQ    <= 1'b0;
    end else if (strb.load) begin
      halfCnt <= '0;
      dclkQ   <= 1'b0;
      riseIdx <= '0;
      unique case (strb.burst)
        BURST_PRE: begin
          pulsesLeft <= N_PRE;
          sampleQ    <= 1'b0;
          syncEnQ    <= 1'b0;
          firstIdx   <= FIRST_EARLY;
        end
        BURST_EARLY: begin
          pulsesLeft <= N_EARLY;
          sampleQ    <= 1'b1;
          syncEnQ    <= 1'b0;
          firstIdx   <= FIRST_EARLY;
        end
        default: begin
          pulsesLeft <= N_LATE;
          sampleQ    <= 1'b1;
          syncEnQ    <= 1'b1;
          firstIdx   <= FIRST_LATE;
        end
      endcase
    end else if (active) begin
      if (edgeNow) begin
        halfCnt <= '0;
        dclkQ   <= !dclkQ;
        if (dclkQ) pulsesLeft <= pulsesLeft - CNT_W'(1);
        else       riseIdx    <= riseNum;
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  // serial capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      syncQ  <= 1'b0;
    end else begin
      if (strb.load) syncQ <= 1'b0;
      else if (takeSync) syncQ <= sdata;
      if (takeBit) shiftQ <= {shiftQ[WORD_W-2:0], sdata};
    end
  end

  // publish or flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      validQ  <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      validQ <= 1'b0;
      errQ   <= 1'b0;
      if (strb.commit) begin
        if (strb.checkSync && !syncQ) begin
          errQ <= 1'b1;
        end else begin
          resultQ <= shiftQ;
          validQ  <= 1'b1;
        end
      end
    end
  end

  assign dataClk     = dclkQ;
  assign genIdle     = !active;
  assign result      = resultQ;
  assign resultValid = validQ;
  assign syncErr     = errQ;

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DIV_W       = 8,
  parameter int CLK_HZ      = 100_000_000,
  parameter int DCLK_MAX_HZ = 15_150_000,
  parameter int CONV_CYC    = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeAfter,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              busyN,
  input  logic              sdata,
  output logic              rdConv,
  output logic              csN,
  output logic              dataClk,
  output logic [WORD_W-1:0] result,
  output logic              resultValid,
  output logic              syncErr,
  output logic              cfgErr
);

  // smallest half period that keeps the data clock at or below its limit
  localparam int MIN_HALF = (CLK_HZ + 2 * DCLK_MAX_HZ - 1) / (2 * DCLK_MAX_HZ);
  // largest half period whose early burst ends inside half the busy time
  localparam int EARLY_MAX_HALF = (CONV_CYC / 2) / (2 * (WORD_W + 1));

  rdStrobe_t strb;
  logic      genIdle;

  adc_rd_ctrl #(
    .DIV_W         (DIV_W),
    .MIN_HALF      (MIN_HALF),
    .EARLY_MAX_HALF(EARLY_MAX_HALF)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeAfter(modeAfter),
    .divHalf  (divHalf),
    .busyN    (busyN),
    .genIdle  (genIdle),
    .strb     (strb),
    .rdConv   (rdConv),
    .csN      (csN),
    .cfgErr   (cfgErr)
  );

  adc_rd_datapath #(
    .WORD_W(WORD_W),
    .DIV_W (DIV_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .divHalf    (divHalf),
    .sdata      (sdata),
    .dataClk    (dataClk),
    .genIdle    (genIdle),
    .result     (result),
    .resultValid(resultValid),
    .syncErr    (syncErr)
  );

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdConv,
  input logic              csN,
  input logic              dataClk,
  input logic              busyN,
  input logic [WORD_W-1:0] result,
  input logic              resultValid,
  input logic              syncErr,
  input logic              cfgErr
);

  // R2: convert request released once busy is seen low
  p_rc_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdConv && !busyN) |=> rdConv);

  // R3: nothing is read or clocked while a conversion is requested
  p_quiet_in_conv_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdConv |-> (csN && !dataClk));

  // R5: a sync failure never comes with a valid word
  p_err_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && syncErr));

  // R6: one-cycle strobe
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6: result only moves with the strobe
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  // R7: a refused start leaves the lines idle
  p_cfg_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (rdConv && csN && !dataClk));

  // R7: each data-clock level lasts more than one system clock
  p_hold_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataClk) |=> dataClk);
  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataClk) |=> !dataClk);

endmodule

bind adc_serial_reader adc_rd_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdConv     (rdConv),
  .csN        (csN),
  .dataClk    (dataClk),
  .busyN      (busyN),
  .result     (result),
  .resultValid(resultValid),
  .syncErr    (syncErr),
  .cfgErr     (cfgErr)
);

// File: tb/test_adc_serial_reader.sv
module test_adc_serial_reader;

  localparam int CONV = 400;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        modeAfter;
  logic [7:0]  divHalf;
  logic        busyN;
  logic        sdata;
  logic        rdConv, csN, dataClk, resultValid, syncErr, cfgErr;
  logic [15:0] result;

  always #5 clk = ~clk;

  adc_serial_reader i_adc_serial_reader (
    .clk(clk), .rstN(rstN), .start(start), .modeAfter(modeAfter),
    .divHalf(divHalf), .busyN(busyN), .sdata(sdata), .rdConv(rdConv),
    .csN(csN), .dataClk(dataClk), .result(result),
    .resultValid(resultValid), .syncErr(syncErr), .cfgErr(cfgErr)
  );

  int nChk = 0;
  int nFail = 0;

  // converter model and monitors
  logic [15:0] adcWord = '0;
  bit          tbLate = 0;
  bit          tbBadSync = 0;
  int busyCnt, fallCnt, n;
  logic rcPrev, dPrev, csPrev, armed;
  int riseAll, riseCsLow, riseBusyLow, rcFalls, lateFalls, hiRun, lastHi;

  assign busyN = (busyCnt == 0);

  always @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= 0; fallCnt <= 0; rcPrev <= 1; dPrev <= 0; csPrev <= 1;
      armed <= 0; sdata <= 0; riseAll <= 0; riseCsLow <= 0;
      riseBusyLow <= 0; rcFalls <= 0; lateFalls <= 0; hiRun <= 0; lastHi <= 0;
    end else begin
      rcPrev <= rdConv; dPrev <= dataClk; csPrev <= csN;
      if (rcPrev && !rdConv) begin
        busyCnt <= CONV; rcFalls <= rcFalls + 1;
      end else if (busyCnt != 0) busyCnt <= busyCnt - 1;
      if (!dPrev && dataClk) begin
        riseAll <= riseAll + 1;
        if (!csN) riseCsLow <= riseCsLow + 1;
        if (!busyN) riseBusyLow <= riseBusyLow + 1;
      end
      if (dataClk) hiRun <= hiRun + 1; else hiRun <= 0;
      if (dPrev && !dataClk) lastHi <= hiRun;
      if (!csPrev && csN) begin
        armed <= 0; fallCnt <= 0;
      end else if (dPrev && !dataClk) begin
        if (csN) begin
          armed <= 1; fallCnt <= 0;
        end else begin
          n = fallCnt + 1;
          fallCnt <= n;
          if (tbLate) begin
            if (n == 1) sdata <= armed && !tbBadSync;
            else if (n <= 17) sdata <= adcWord[17-n];
          end else begin
            if (n <= 16) sdata <= adcWord[16-n];
            if (busyN || (CONV - busyCnt) > CONV / 2) lateFalls <= lateFalls + 1;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitOutcome(output bit v, output bit e, output bit oneCyc);
    v = 0; e = 0; oneCyc = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (resultValid || syncErr) begin
        v = resultValid; e = syncErr;
        @(negedge clk);
        oneCyc = !resultValid && !syncErr;
        return;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "rdConv", rdConv, 1);
    chk("R1", "csN", csN, 1);
    chk("R1", "dataClk", dataClk, 0);
    chk("R1", "result", result, 0);
    chk("R1", "valid/err", {resultValid, syncErr, cfgErr}, 0);
  endtask

  task automatic t_early(input int div, input logic [15:0] w);
    int a0, c0, r0, l0;
    bit v, e, one;
    modeAfter = 0; divHalf = 8'(div); tbLate = 0; tbBadSync = 0; adcWord = w;
    a0 = riseAll; c0 = riseCsLow; r0 = rcFalls; l0 = lateFalls;
    pulseStart();
    waitOutcome(v, e, one);
    chk("R6", "early valid", v, 1);
    chk("R6", "early one cycle", one, 1);
    chk("R3", "early word", result, w);
    chk("R3", "early pulses cs low", riseCsLow - c0, 17);
    chk("R3", "early pulses total", riseAll - a0, 17);
    chk("R3", "early late falls", lateFalls - l0, 0);
    chk("R2", "one conversion", rcFalls - r0, 1);
    chk("R7", "high length", lastHi, div);
  endtask

  task automatic t_late(input int div, input logic [15:0] w, input bit bad);
    int a0, c0, b0;
    logic [15:0] prev;
    bit v, e, one;
    modeAfter = 1; divHalf = 8'(div); tbLate = 1; tbBadSync = bad; adcWord = w;
    a0 = riseAll; c0 = riseCsLow; b0 = riseBusyLow; prev = result;
    pulseStart();
    waitOutcome(v, e, one);
    chk("R4", "late pulses total", riseAll - a0, 19);
    chk("R4", "late pulses cs low", riseCsLow - c0, 18);
    chk("R4", "edges while busy", riseBusyLow - b0, 0);
    chk("R7", "high length", lastHi, div);
    if (!bad) begin
      chk("R6", "late valid", {v, e}, 2'b10);
      chk("R6", "late one cycle", one, 1);
      chk("R4", "late word", result, w);
    end else begin
      chk("R5", "sync error flags", {v, e}, 2'b01);
      chk("R5", "sync error one cycle", one, 1);
      chk("R5", "result kept", result, prev);
    end
  endtask

  task automatic t_reject(input bit late, input int div, input string req);
    int a0, r0;
    bit sawValid;
    modeAfter = late; divHalf = 8'(div); tbLate = late;
    a0 = riseAll; r0 = rcFalls; sawValid = 0;
    pulseStart();
    chk(req, "cfgErr raised", cfgErr, 1);
    @(negedge clk);
    chk(req, "cfgErr one cycle", cfgErr, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (resultValid) sawValid = 1;
    end
    chk(req, "no conversion", rcFalls - r0, 0);
    chk(req, "no clocks", riseAll - a0, 0);
    chk(req, "no valid", sawValid, 0);
  endtask

  task automatic t_ignore();
    int r0;
    bit v, e, one;
    modeAfter = 0; divHalf = 8'd4; tbLate = 0; tbBadSync = 0; adcWord = 16'h5A0F;
    r0 = rcFalls;
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    chk("R9", "no cfgErr on busy start", cfgErr, 0);
    waitOutcome(v, e, one);
    chk("R9", "first read completes", result, 16'h5A0F);
    repeat (600) @(negedge clk);
    chk("R9", "extra start ignored", rcFalls - r0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rstN = 0; start = 0; modeAfter = 0; divHalf = 8'd4;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_early(4, 16'hA5C3);
    t_early(5, 16'h8001);
    t_reject(0, 6, "R8");
    t_reject(1, 3, "R7");
    t_reject(0, 0, "R7");
    t_late(4, 16'h1234, 0);
    t_late(6, 16'hBEEF, 0);
    t_late(9, 16'h7F01, 0);
    t_late(4, 16'h0F0F, 1);
    t_ignore();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule